// File: doc/BRIEF.md
# Grouped Interrupt Expander with Group Acknowledge

This block gathers many interrupt request lines and funnels them onto a few CPU interrupt channels. The lines are arranged as `NUM_GROUPS` groups of `GRP_LINES` lines each. By default there are 12 groups of 8 lines, 96 requests in all. Every line has a sticky pending flag and a line enable. Each group ORs its enabled pending lines into one request towards the CPU. That request is issued as a single-cycle pulse. While the group's acknowledge bit is set, the group issues no further pulses.

On the CPU side, each group pulse sets a per-group CPU flag. A per-group CPU enable and one global mask then decide whether an interrupt is presented. When an interrupt is presented, the block drives `irq_take` together with the winning group and line. The CPU answers with `vec_ack` in a cycle where `irq_take` is high. That handshake updates the state in four ways:
- It clears the winning line's pending flag.
- It clears that group's CPU flag.
- It sets the group's acknowledge bit.
- It sets the global mask, so no further interrupt is presented until software reopens it.

Software reaches all of this through a single-cycle write port. Vector tables and handler execution are outside this block.

Top module: `irqx_expander`

## Requirements
- R1: A request on line l of group g (input bit g*GRP_LINES+l) sets that line's pending flag, whether or not the line is enabled. Enabling the line later lets the interrupt through.
- R2: A group emits a one-cycle pulse, which sets its CPU flag, when two conditions meet: at least one of its lines is both pending and enabled, and its acknowledge bit is clear. No second pulse follows until that condition has dropped.
- R3: Within a group, line 0 has the highest priority and line GRP_LINES-1 the lowest. `irq_line` reports the highest-priority line that is both pending and enabled.
- R4: Accepting an interrupt (`irq_take` and `vec_ack` in the same cycle) sets the group's acknowledge bit, which blocks new pulses from that group. Writing 1 to the group's bit clears the acknowledge. If an enabled line is still pending at that point, a fresh pulse follows.
- R5: `irq_take` is high only when three conditions hold: some group has its CPU flag set, that group's CPU enable is 1, and the global mask is 0. The global mask resets to 1.
- R6: Among the groups that are ready, group 0 wins and higher-numbered groups lose. `irq_group` reports the winner.
- R7: Accepting an interrupt clears the reported line's pending flag and the group's CPU flag, and sets the global mask. `irq_take` is therefore low in the following cycle.
- R8: Writing 1s to the CPU flag clear register clears only the CPU flags of the selected groups. The other groups' CPU flags are left untouched.
- R9: A request that arrives on a line in the same cycle as that line's flag is cleared by acceptance leaves the flag set.
- R10: Writing 1s to a group's line flag clear register clears the selected pending flags. Bits written as 0 are left as they are.
- R11: After reset, all flags, enables and acknowledge bits are 0, and `irq_take` is low.
- R12: A write is one cycle with `wr_en` high. `wr_addr` is made of {kind[2:0], group[GW-1:0]}, and the kind selects the action:
  - kind 0 loads the line enables of the addressed group from `wr_data`.
  - kind 1 clears the addressed group's line flags where `wr_data` has a 1.
  - kind 2 clears the acknowledge bits of the groups whose bit in `wr_data` is 1.
  - kind 3 loads the CPU enables from `wr_data`.
  - kind 4 clears the CPU flags of the groups whose bit in `wr_data` is 1.
  - kind 5 loads the global mask from `wr_data[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NUM_GROUPS*GRP_LINES | Request lines; bit g*GRP_LINES+l is line l of group g |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3+GW | Write kind in the upper bits, group index in the lower bits |
| wr_data | input | max(NUM_GROUPS,GRP_LINES) | Write data |
| vec_ack | input | 1 | CPU accepts the presented interrupt |
| irq_take | output | 1 | An interrupt is presented to the CPU |
| irq_group | output | GW | Winning group index |
| irq_line | output | LW | Winning line index within that group |
| irq_hit | output | 1 | `irq_line` names a pending, enabled line |

## Verification
The bench drives several request patterns:
- A lone request checks the basic path.
- Two lines of one group fired together separate the in-group priority from the acknowledge-release re-pulse.
- Two groups fired together expose the group priority.
- Requests made while a line enable, a CPU enable or the global mask is closed show whether the pending state survives until the gate opens.
- A held acknowledge, a selective CPU-flag clear and a line-flag clear while the line is disabled each have to produce exactly the interrupts they should, and no others.
- A request placed in the same cycle as acceptance must cause a second, identical interrupt. This tells a flag that set-wins apart from one that clear-wins.

// File: rtl/irqx_pkg.sv
package irqx_pkg;

    localparam int KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        K_LINE_EN      = 3'd0,
        K_FLAG_CLR     = 3'd1,
        K_ACK_CLR      = 3'd2,
        K_CPU_EN       = 3'd3,
        K_CPU_FLAG_CLR = 3'd4,
        K_GMASK        = 3'd5
    } wr_kind_e;

endpackage

// File: rtl/irqx_prio.sv
// Fixed-priority finder: the lowest set index wins.
module irqx_prio #(
    parameter  int N = 8,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] vec,
    output logic         hit,
    output logic [W-1:0] idx
);

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                hit = 1'b1;
                idx = W'(i);
            end
        end
    end

endmodule

// File: rtl/irqx_group.sv
// One group: pending flags, line enables, acknowledge, pulse generation.
module irqx_group #(
    parameter  int LINES = 8,
    localparam int LW    = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] req,
    input  logic             en_wr,
    input  logic             flag_clr,
    input  logic [LINES-1:0] wr_data,
    input  logic             ack_clr,
    input  logic             fetch,
    output logic             pulse,
    output logic             hit,
    output logic [LW-1:0]    line,
    output logic             ack
);

    typedef struct packed {
        logic [LINES-1:0] flag;
        logic [LINES-1:0] en;
        logic             ack;
        logic             req_prev;
    } grp_st_t;

    grp_st_t          st_q, st_d;
    logic [LINES-1:0] live;
    logic [LINES-1:0] clr_vec;
    logic             req_now;

    assign live = st_q.flag & st_q.en;
    assign ack  = st_q.ack;

    irqx_prio #(.N(LINES)) u_prio (
        .vec (live),
        .hit (hit),
        .idx (line)
    );

    always_comb begin
        // group request level and its rising edge
        req_now = (|live) & ~st_q.ack;
        pulse   = req_now & ~st_q.req_prev;

        clr_vec = flag_clr ? wr_data : '0;
        if (fetch && hit) begin
            clr_vec[line] = 1'b1;
        end

        st_d          = st_q;
        // a request wins over any clear in the same cycle
        st_d.flag     = (st_q.flag & ~clr_vec) | req;
        if (en_wr) begin
            st_d.en = wr_data;
        end
        if (fetch) begin
            st_d.ack = 1'b1;
        end else if (ack_clr) begin
            st_d.ack = 1'b0;
        end
        st_d.req_prev = req_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/irqx_cpu.sv
// CPU side: per-group flag latch, per-group enable, global mask, group pick.
module irqx_cpu #(
    parameter  int NG = 12,
    parameter  int DW = 12,
    localparam int GW = (NG > 1) ? $clog2(NG) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NG-1:0] pulse,
    input  logic          cen_wr,
    input  logic          cflag_clr,
    input  logic          gmask_wr,
    input  logic [DW-1:0] wr_data,
    input  logic          vec_ack,
    output logic          take,
    output logic [GW-1:0] grp,
    output logic          gmask,
    output logic [NG-1:0] fetch_vec
);

    typedef struct packed {
        logic [NG-1:0] cflag;
        logic [NG-1:0] cen;
        logic          gmask;
    } cpu_st_t;

    cpu_st_t       st_q, st_d;
    logic [NG-1:0] ready;
    logic [NG-1:0] sw_clr;
    logic          any_ready;
    logic          accept;

    assign ready = st_q.cflag & st_q.cen;
    assign gmask = st_q.gmask;

    irqx_prio #(.N(NG)) u_prio (
        .vec (ready),
        .hit (any_ready),
        .idx (grp)
    );

    always_comb begin
        take      = any_ready & ~st_q.gmask;
        accept    = take & vec_ack;
        fetch_vec = '0;
        if (accept) begin
            fetch_vec[grp] = 1'b1;
        end
        sw_clr = cflag_clr ? wr_data[NG-1:0] : '0;

        st_d       = st_q;
        st_d.cflag = (st_q.cflag & ~sw_clr & ~fetch_vec) | pulse;
        if (cen_wr) begin
            st_d.cen = wr_data[NG-1:0];
        end
        if (accept) begin
            st_d.gmask = 1'b1;
        end else if (gmask_wr) begin
            st_d.gmask = wr_data[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cflag: '0, cen: '0, gmask: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/irqx_expander.sv
module irqx_expander
    import irqx_pkg::*;
#(
    parameter  int NUM_GROUPS = 12,
    parameter  int GRP_LINES  = 8,
    localparam int GW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
    localparam int LW = (GRP_LINES > 1) ? $clog2(GRP_LINES) : 1,
    localparam int DW = (NUM_GROUPS > GRP_LINES) ? NUM_GROUPS : GRP_LINES,
    localparam int AW = KIND_W + GW
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_GROUPS*GRP_LINES-1:0] irq_req,
    input  logic                            wr_en,
    input  logic [AW-1:0]                   wr_addr,
    input  logic [DW-1:0]                   wr_data,
    input  logic                            vec_ack,
    output logic                            irq_take,
    output logic [GW-1:0]                   irq_group,
    output logic [LW-1:0]                   irq_line,
    output logic                            irq_hit
);

    wr_kind_e                kind;
    logic [GW-1:0]           wgrp;
    logic [NUM_GROUPS-1:0]   grp_pulse;
    logic [NUM_GROUPS-1:0]   grp_ack;
    logic [NUM_GROUPS-1:0]   grp_hit;
    logic [NUM_GROUPS-1:0]   fetch_vec;
    logic [LW-1:0]           grp_line [NUM_GROUPS];
    logic                    gmask_w;

    assign kind = wr_kind_e'(wr_addr[AW-1:GW]);
    assign wgrp = wr_addr[GW-1:0];

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        irqx_group #(.LINES(GRP_LINES)) u_grp (
            .clk      (clk),
            .rst_n    (rst_n),
            .req      (irq_req[g*GRP_LINES +: GRP_LINES]),
            .en_wr    (wr_en && kind == K_LINE_EN && wgrp == GW'(g)),
            .flag_clr (wr_en && kind == K_FLAG_CLR && wgrp == GW'(g)),
            .wr_data  (wr_data[GRP_LINES-1:0]),
            .ack_clr  (wr_en && kind == K_ACK_CLR && wr_data[g]),
            .fetch    (fetch_vec[g]),
            .pulse    (grp_pulse[g]),
            .hit      (grp_hit[g]),
            .line     (grp_line[g]),
            .ack      (grp_ack[g])
        );
    end

    irqx_cpu #(.NG(NUM_GROUPS), .DW(DW)) u_cpu (
        .clk       (clk),
        .rst_n     (rst_n),
        .pulse     (grp_pulse),
        .cen_wr    (wr_en && kind == K_CPU_EN),
        .cflag_clr (wr_en && kind == K_CPU_FLAG_CLR),
        .gmask_wr  (wr_en && kind == K_GMASK),
        .wr_data   (wr_data),
        .vec_ack   (vec_ack),
        .take      (irq_take),
        .grp       (irq_group),
        .gmask     (gmask_w),
        .fetch_vec (fetch_vec)
    );

    assign irq_line = grp_line[irq_group];
    assign irq_hit  = irq_take & grp_hit[irq_group];

endmodule

// File: rtl/irqx_chk.sv
module irqx_chk #(
    parameter int NG = 12,
    parameter int GW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq_take,
    input logic [GW-1:0] irq_group,
    input logic          vec_ack,
    input logic [NG-1:0] grp_pulse,
    input logic [NG-1:0] grp_ack,
    input logic          gmask
);

    logic          fetched_q;
    logic [GW-1:0] fgrp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetched_q <= 1'b0;
            fgrp_q    <= '0;
        end else begin
            fetched_q <= irq_take && vec_ack;
            fgrp_q    <= irq_group;
        end
    end

    // R5: a set global mask hides every group
    a_r5_mask_blocks_take: assert property (@(posedge clk) disable iff (!rst_n)
        gmask |-> !irq_take);

    // R7: acceptance raises the global mask
    a_r7_fetch_sets_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && vec_ack) |=> gmask);

    // R4: acceptance raises the group acknowledge
    a_r4_fetch_sets_ack: assert property (@(posedge clk) disable iff (!rst_n)
        fetched_q |-> grp_ack[fgrp_q]);

    // R2: group pulses last exactly one cycle
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_pulse != '0) |=> ((grp_pulse & $past(grp_pulse)) == '0));

    // R6: the reported group always exists
    a_r6_group_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> (int'(irq_group) < NG));

endmodule

bind irqx_expander irqx_chk #(.NG(NUM_GROUPS), .GW(GW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_take  (irq_take),
    .irq_group (irq_group),
    .vec_ack   (vec_ack),
    .grp_pulse (grp_pulse),
    .grp_ack   (grp_ack),
    .gmask     (gmask_w)
);

// File: tb/sim_irqx_expander.sv
`timescale 1ns/1ps
module sim_irqx_expander;

    localparam int NG = 12;
    localparam int NL = 8;
    localparam int GW = 4;
    localparam int LW = 3;
    localparam int DW = 12;
    localparam int AW = 3 + GW;

    localparam int K_LINE_EN = 0, K_FLAG_CLR = 1, K_ACK_CLR = 2;
    localparam int K_CPU_EN = 3, K_CPU_FLAG_CLR = 4, K_GMASK = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [NG*NL-1:0] drv_req = '0, col_req = '0;
    logic             drv_wen = 1'b0, mon_wen = 1'b0;
    logic [AW-1:0]    drv_wa = '0, mon_wa = '0;
    logic [DW-1:0]    drv_wd = '0, mon_wd = '0;
    logic             vec_ack = 1'b0;
    logic             irq_take, irq_hit;
    logic [GW-1:0]    irq_group;
    logic [LW-1:0]    irq_line;

    irqx_expander u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_req   (drv_req | col_req),
        .wr_en     (drv_wen | mon_wen),
        .wr_addr   (drv_wa | mon_wa),
        .wr_data   (drv_wd | mon_wd),
        .vec_ack   (vec_ack),
        .irq_take  (irq_take),
        .irq_group (irq_group),
        .irq_line  (irq_line),
        .irq_hit   (irq_hit)
    );

    typedef struct {
        int    g;
        int    l;
        string r;
    } item_t;

    item_t exp_q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    auto_ack = 1'b1;
    bit    collide = 1'b0;

    task automatic check(bit ok, string r, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    task automatic drv_write(int kind, int grp, logic [DW-1:0] d);
        @(negedge clk);
        drv_wen = 1'b1;
        drv_wa  = AW'((kind << GW) | grp);
        drv_wd  = d;
        @(negedge clk);
        drv_wen = 1'b0;
        drv_wa  = '0;
        drv_wd  = '0;
    endtask

    task automatic mon_write(int kind, int grp, logic [DW-1:0] d);
        @(negedge clk);
        mon_wen = 1'b1;
        mon_wa  = AW'((kind << GW) | grp);
        mon_wd  = d;
        @(negedge clk);
        mon_wen = 1'b0;
        mon_wa  = '0;
        mon_wd  = '0;
    endtask

    task automatic fire(int g, int l);
        @(negedge clk);
        drv_req[g*NL+l] = 1'b1;
        @(negedge clk);
        drv_req = '0;
    endtask

    task automatic fire2(int g1, int l1, int g2, int l2);
        @(negedge clk);
        drv_req[g1*NL+l1] = 1'b1;
        drv_req[g2*NL+l2] = 1'b1;
        @(negedge clk);
        drv_req = '0;
    endtask

    task automatic expect_take(int g, int l, string r);
        item_t it;
        it.g = g;
        it.l = l;
        it.r = r;
        exp_q.push_back(it);
    endtask

    task automatic settle(string r);
        for (int i = 0; i < 300 && exp_q.size() != 0; i++) @(negedge clk);
        if (exp_q.size() != 0) begin
            check(1'b0, {r, " missing take"}, 0, exp_q.size());
            exp_q.delete();
        end
        repeat (12) @(negedge clk);
    endtask

    task automatic quiet(string r);
        repeat (12) @(negedge clk);
        check(irq_take == 1'b0, {r, " no take expected"}, int'(irq_take), 0);
    endtask

    // monitor: plays the CPU, compares each presented interrupt with the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && irq_take) begin
                automatic int g = int'(irq_group);
                automatic int l = int'(irq_line);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected take", g*NL+l, -1);
                end else begin
                    automatic item_t e = exp_q.pop_front();
                    check(g == e.g && l == e.l && irq_hit, e.r, g*NL+l, e.g*NL+e.l);
                end
                vec_ack = 1'b1;
                if (collide) begin
                    col_req[g*NL+l] = 1'b1;   // R9 collision
                    collide = 1'b0;
                end
                @(negedge clk);
                vec_ack = 1'b0;
                col_req = '0;
                check(irq_take == 1'b0, "R7 take after accept", int'(irq_take), 0);
                if (auto_ack) mon_write(K_ACK_CLR, 0, DW'(1) << g);
                mon_write(K_GMASK, 0, '0);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(irq_take == 1'b0, "R11 take in reset", int'(irq_take), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(irq_take == 1'b0, "R11 take after reset", int'(irq_take), 0);
        check(irq_hit == 1'b0, "R11 hit after reset", int'(irq_hit), 0);

        // R12: configuration through the write port
        for (int g = 0; g < NG; g++) drv_write(K_LINE_EN, g, 'hff);
        drv_write(K_CPU_EN, 0, 'hfff);
        // mask still at reset value 1: nothing may be taken yet (R5)
        fire(3, 0);
        quiet("R5");
        expect_take(3, 0, "R5");
        drv_write(K_GMASK, 0, '0);
        settle("R5");

        // R2: single request
        expect_take(3, 5, "R2");
        fire(3, 5);
        settle("R2");

        // R3 then R4: two lines of one group, second after ack release
        expect_take(2, 1, "R3");
        expect_take(2, 6, "R4");
        fire2(2, 6, 2, 1);
        settle("R3");

        // R6: two groups at once
        expect_take(1, 3, "R6");
        expect_take(7, 0, "R6");
        fire2(7, 0, 1, 3);
        settle("R6");

        // R1: flag latches while the line is disabled
        drv_write(K_LINE_EN, 0, 'hef);
        fire(0, 4);
        quiet("R1");
        expect_take(0, 4, "R1");
        drv_write(K_LINE_EN, 0, 'hff);
        settle("R1");

        // R5: CPU enable closed for group 5
        drv_write(K_CPU_EN, 0, 'hfff & ~(12'h1 << 5));
        fire(5, 2);
        quiet("R5");
        expect_take(5, 2, "R5");
        drv_write(K_CPU_EN, 0, 'hfff);
        settle("R5");

        // R5: global mask closed
        drv_write(K_GMASK, 0, 'h1);
        fire(4, 7);
        quiet("R5");
        expect_take(4, 7, "R5");
        drv_write(K_GMASK, 0, '0);
        settle("R5");

        // R4: acknowledge held blocks the group until software clears it
        auto_ack = 1'b0;
        expect_take(6, 1, "R4");
        fire(6, 1);
        settle("R4");
        fire(6, 2);
        quiet("R4");
        expect_take(6, 2, "R4");
        auto_ack = 1'b1;
        drv_write(K_ACK_CLR, 0, 'h1 << 6);
        settle("R4");

        // R8: clearing one CPU flag leaves the other group alone
        drv_write(K_GMASK, 0, 'h1);
        fire2(8, 0, 9, 0);
        repeat (6) @(negedge clk);
        drv_write(K_CPU_FLAG_CLR, 0, 'h1 << 8);
        expect_take(9, 0, "R8");
        drv_write(K_GMASK, 0, '0);
        settle("R8");
        quiet("R8");
        drv_write(K_FLAG_CLR, 8, 'h01);

        // R9: request in the same cycle as acceptance is kept
        collide = 1'b1;
        expect_take(10, 3, "R9");
        expect_take(10, 3, "R9");
        fire(10, 3);
        settle("R9");

        // R10: software clears a pending line flag before it is enabled
        drv_write(K_LINE_EN, 11, '0);
        fire(11, 6);
        drv_write(K_FLAG_CLR, 11, 'h40);
        drv_write(K_LINE_EN, 11, 'hff);
        quiet("R10");

        // R12: highest group and line index decode
        expect_take(11, 7, "R12");
        fire(11, 7);
        settle("R12");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule